// File: doc/BRIEF.md
# Floating-Point Exception Qualifier Trap Filter

This block sits after the arithmetic of a floating-point unit and decides what happens to the exception flags of one completed instruction. On each instruction it receives six raw flags, the instruction's three qualifier bits and the destination register number:

- Raw flags: invalid, divide-by-zero, overflow, underflow, inexact and integer overflow.
- Qualifiers: underflow/integer-overflow enable, inexact enable and software completion.

It also receives the per-exception disable mask held in the floating-point control register, and the address of the instruction.

Every raised flag is accumulated into sticky status bits, whatever the qualifiers say. A summary bit is the OR of the sticky bits. The qualifiers select which flags are eligible to trap. Under software completion the control-register disable mask removes further flags. If any flag is left, a one-cycle trap request is issued. The request carries:

- an exception-summary word;
- a one-hot destination-register mask;
- the resume address, which is the instruction address plus 4.

Top module: `fp_trap_filter`

## Requirements
- R1: One cycle after `in_valid`, each raised flag is set in `sticky`. This happens whatever the qualifiers and the disable mask are. Sticky bits only clear on reset. Flag bit order for `raw_flags`, `dis_mask` and `sticky` is 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact, 5 integer overflow.
- R2: `summary` is 1 exactly when at least one `sticky` bit is 1. It follows `sticky` in the same cycle.
- R3: Inexact is eligible to trap only when `q_inexact` is 1.
- R4: Underflow and integer overflow are eligible to trap only when `q_underflow` is 1.
- R5: Invalid, divide-by-zero and overflow are always eligible to trap.
- R6: With `q_swc` at 1, an eligible flag whose `dis_mask` bit is 1 does not trap. With `q_swc` at 0, `dis_mask` has no effect on the trap.
- R7: `trap_sum` bit 0 is the software-completion bit and equals `q_swc`. Bits 1..6 hold the surviving flags in the R1 order, so bit 1 is invalid and bit 6 is integer overflow.
- R8: `trap_regmask` has exactly one bit set, at position `dst_reg` + 32.
- R9: `trap_pc` equals `inst_pc` + 4.
- R10: `trap_valid` pulses for one cycle, one cycle after `in_valid`, and only if at least one flag survives filtering. Otherwise it stays 0.
- R11: `status_word` bit 63 is `summary` and bit 62 is `dis_mask` bit 4 (inexact disable). Bits 52..57 are `sticky` bits 0..5. All other bits are 0.
- R12: A synchronous reset clears `sticky`, `summary` and `trap_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One instruction's flags are presented this cycle |
| raw_flags | input | 6 | Raw exception flags of the instruction |
| q_underflow | input | 1 | Underflow/integer-overflow trap qualifier |
| q_inexact | input | 1 | Inexact trap qualifier |
| q_swc | input | 1 | Software-completion qualifier |
| dst_reg | input | 5 | Destination floating-point register number |
| inst_pc | input | 64 | Address of the instruction |
| dis_mask | input | 6 | Control-register per-exception disable mask |
| sticky | output | 6 | Accumulated status flags |
| summary | output | 1 | OR of the status flags |
| status_word | output | 64 | Control-register view of status, summary and inexact disable |
| trap_valid | output | 1 | One-cycle trap request |
| trap_sum | output | 7 | Exception summary of the trap |
| trap_regmask | output | 64 | Destination-register mask of the trap |
| trap_pc | output | 64 | Resume address of the trap |

## Verification
A fault in the ignore-set logic would appear as `trap_valid` either missing or spurious one cycle after the instruction. It would also leave a wrong bit in `trap_sum` in that same cycle. Lost or dropped sticky state shows at `sticky`, `summary` and `status_word` on the cycle after the instruction. The fault then persists, because those bits only clear on reset. A fault in the trap payload (register mask, resume address, software-completion bit) shows only in the single cycle of the pulse. The scenarios therefore sample exactly that cycle and the one after it.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int unsigned NFLAG  = 6;
    localparam int unsigned STAT_W = 64;
    localparam int unsigned SUMMARY_BIT  = 63;
    localparam int unsigned INE_DIS_BIT  = 62;
    localparam int unsigned STICKY_LSB   = 52;

    // bit 0 invalid ... bit 5 integer overflow
    typedef struct packed {
        logic iov;
        logic ine;
        logic unf;
        logic ovf;
        logic dze;
        logic inv;
    } fpx_flags_t;

    typedef struct packed {
        fpx_flags_t flags;
        logic       swc;
    } fpx_sum_t;

    // Flags removed from trapping by the qualifiers
    function automatic fpx_flags_t fpx_ignore(input logic q_unf, input logic q_ine);
        fpx_flags_t ign;
        ign     = '0;
        ign.ine = 1'b1;
        if (!q_unf) begin
            ign.unf = 1'b1;
            ign.iov = 1'b1;
        end
        if (q_ine) begin
            ign.ine = 1'b0;
        end
        return ign;
    endfunction

endpackage

// File: rtl/fpx_qual_filter.sv
module fpx_qual_filter
    import fpx_pkg::*;
(
    input  fpx_flags_t raw,
    input  logic       q_unf,
    input  logic       q_ine,
    input  logic       q_swc,
    input  fpx_flags_t disable_mask,
    output fpx_flags_t survivors,
    output logic       any_survivor
);

    fpx_flags_t eligible;
    fpx_flags_t ctl_pass;

    always_comb begin
        eligible = raw & ~fpx_ignore(q_unf, q_ine);
        ctl_pass = q_swc ? ~disable_mask : '1;
        survivors = eligible & ctl_pass;
        any_survivor = |survivors;
    end

endmodule

// File: rtl/fpx_sticky.sv
module fpx_sticky
    import fpx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  fpx_flags_t          raw,
    input  logic                ine_disable,
    output fpx_flags_t          status,
    output logic                summary,
    output logic [STAT_W-1:0]   status_word
);

    fpx_flags_t status_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else if (in_valid) begin
            status_q <= status_q | raw;
        end
    end

    always_comb begin
        status  = status_q;
        summary = |status_q;
        status_word = '0;
        status_word[SUMMARY_BIT] = summary;
        status_word[INE_DIS_BIT] = ine_disable;
        status_word[STICKY_LSB +: NFLAG] = status_q;
    end

endmodule

// File: rtl/fpx_trap_gen.sv
module fpx_trap_gen
    import fpx_pkg::*;
#(
    parameter int unsigned NUM_FREG = 32,
    parameter int unsigned PC_W     = 64,
    parameter int unsigned PC_STEP  = 4,
    localparam int unsigned REG_W   = $clog2(NUM_FREG),
    localparam int unsigned MASK_W  = 2 * NUM_FREG
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              fire,
    input  fpx_flags_t        survivors,
    input  logic              swc,
    input  logic [REG_W-1:0]  dst_reg,
    input  logic [PC_W-1:0]   inst_pc,
    output logic              trap_valid,
    output fpx_sum_t          trap_sum,
    output logic [MASK_W-1:0] trap_regmask,
    output logic [PC_W-1:0]   trap_pc
);

    localparam int unsigned SHIFT_W = $clog2(MASK_W);

    logic [SHIFT_W-1:0] bit_pos;
    logic [MASK_W-1:0]  regmask_d;

    always_comb begin
        bit_pos   = SHIFT_W'(dst_reg) + SHIFT_W'(NUM_FREG);
        regmask_d = MASK_W'(1) << bit_pos;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_valid   <= 1'b0;
            trap_sum     <= '0;
            trap_regmask <= '0;
            trap_pc      <= '0;
        end else begin
            trap_valid <= in_valid && fire;
            if (in_valid && fire) begin
                trap_sum.flags <= survivors;
                trap_sum.swc   <= swc;
                trap_regmask   <= regmask_d;
                trap_pc        <= inst_pc + PC_W'(PC_STEP);
            end
        end
    end

endmodule

// File: rtl/fp_trap_filter.sv
module fp_trap_filter
    import fpx_pkg::*;
#(
    parameter int unsigned NUM_FREG = 32,
    parameter int unsigned PC_W     = 64,
    parameter int unsigned PC_STEP  = 4,
    localparam int unsigned REG_W   = $clog2(NUM_FREG),
    localparam int unsigned MASK_W  = 2 * NUM_FREG
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [NFLAG-1:0]  raw_flags,
    input  logic              q_underflow,
    input  logic              q_inexact,
    input  logic              q_swc,
    input  logic [REG_W-1:0]  dst_reg,
    input  logic [PC_W-1:0]   inst_pc,
    input  logic [NFLAG-1:0]  dis_mask,
    output logic [NFLAG-1:0]  sticky,
    output logic              summary,
    output logic [STAT_W-1:0] status_word,
    output logic              trap_valid,
    output logic [NFLAG:0]    trap_sum,
    output logic [MASK_W-1:0] trap_regmask,
    output logic [PC_W-1:0]   trap_pc
);

    fpx_flags_t raw_s;
    fpx_flags_t dis_s;
    fpx_flags_t survivors;
    fpx_flags_t status_s;
    fpx_sum_t   sum_s;
    logic       fire;

    assign raw_s = fpx_flags_t'(raw_flags);
    assign dis_s = fpx_flags_t'(dis_mask);

    fpx_qual_filter u_filter (
        .raw          (raw_s),
        .q_unf        (q_underflow),
        .q_ine        (q_inexact),
        .q_swc        (q_swc),
        .disable_mask (dis_s),
        .survivors    (survivors),
        .any_survivor (fire)
    );

    fpx_sticky u_sticky (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .raw         (raw_s),
        .ine_disable (dis_s.ine),
        .status      (status_s),
        .summary     (summary),
        .status_word (status_word)
    );

    fpx_trap_gen #(
        .NUM_FREG (NUM_FREG),
        .PC_W     (PC_W),
        .PC_STEP  (PC_STEP)
    ) u_trap (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .fire         (fire),
        .survivors    (survivors),
        .swc          (q_swc),
        .dst_reg      (dst_reg),
        .inst_pc      (inst_pc),
        .trap_valid   (trap_valid),
        .trap_sum     (sum_s),
        .trap_regmask (trap_regmask),
        .trap_pc      (trap_pc)
    );

    assign sticky   = status_s;
    assign trap_sum = sum_s;

endmodule

// File: rtl/fp_trap_filter_chk.sv
module fp_trap_filter_chk
    import fpx_pkg::*;
#(
    parameter int unsigned NUM_FREG = 32,
    parameter int unsigned PC_W     = 64,
    parameter int unsigned PC_STEP  = 4,
    localparam int unsigned REG_W   = $clog2(NUM_FREG),
    localparam int unsigned MASK_W  = 2 * NUM_FREG
)(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [NFLAG-1:0]  raw_flags,
    input logic              q_underflow,
    input logic              q_inexact,
    input logic              q_swc,
    input logic [REG_W-1:0]  dst_reg,
    input logic [PC_W-1:0]   inst_pc,
    input logic [NFLAG-1:0]  dis_mask,
    input logic [NFLAG-1:0]  sticky,
    input logic              summary,
    input logic [STAT_W-1:0] status_word,
    input logic              trap_valid,
    input logic [NFLAG:0]    trap_sum,
    input logic [MASK_W-1:0] trap_regmask,
    input logic [PC_W-1:0]   trap_pc
);

    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (($past(sticky) & ~sticky) == '0)) else $error("sticky cleared"); // R1

    AST_STICKY_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ((sticky & $past(raw_flags)) == $past(raw_flags))) else $error("flag lost"); // R1

    AST_SUMMARY_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(summary) |-> $past(in_valid)) else $error("summary rose alone"); // R2

    AST_INE_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && trap_sum[5]) |-> $past(q_inexact)) else $error("inexact trap"); // R3

    AST_UNF_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && (trap_sum[4] || trap_sum[6])) |-> $past(q_underflow)) else $error("unf/iov trap"); // R4

    AST_SWC_BIT: assert property (@(posedge clk) disable iff (rst)
        trap_valid |-> (trap_sum[0] == $past(q_swc))) else $error("swc bit"); // R7

    AST_REGMASK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        trap_valid |-> ($countones(trap_regmask) == 1 && trap_regmask[MASK_W-1:NUM_FREG] != '0)) else $error("regmask"); // R8

    AST_RESUME_PC: assert property (@(posedge clk) disable iff (rst)
        trap_valid |-> (trap_pc == $past(inst_pc) + PC_W'(PC_STEP))) else $error("resume pc"); // R9

    AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (rst)
        trap_valid |-> ($past(in_valid) && trap_sum[NFLAG:1] != '0)) else $error("trap without cause"); // R10

    AST_STATUS_TOP: assert property (@(posedge clk) disable iff (rst)
        (status_word[63] == summary && status_word[62] == dis_mask[4])) else $error("status word"); // R11

endmodule

bind fp_trap_filter fp_trap_filter_chk #(
    .NUM_FREG (NUM_FREG),
    .PC_W     (PC_W),
    .PC_STEP  (PC_STEP)
) u_chk (.*);

// File: tb/fp_trap_filter_bench.sv
module fp_trap_filter_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [5:0]  raw_flags;
    logic        q_underflow, q_inexact, q_swc;
    logic [4:0]  dst_reg;
    logic [63:0] inst_pc;
    logic [5:0]  dis_mask;
    logic [5:0]  sticky;
    logic        summary;
    logic [63:0] status_word;
    logic        trap_valid;
    logic [6:0]  trap_sum;
    logic [63:0] trap_regmask;
    logic [63:0] trap_pc;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    localparam logic [5:0] F_INV = 6'h01, F_DZE = 6'h02, F_OVF = 6'h04,
                           F_UNF = 6'h08, F_INE = 6'h10, F_IOV = 6'h20;

    always #4 clk = ~clk;

    fp_trap_filter u_fp_trap_filter (.*);

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // expected trap summary from the requirements (R3..R7)
    function automatic logic [6:0] exp_sum(input logic [5:0] f, input logic u,
                                           input logic i, input logic s, input logic [5:0] m);
        logic [5:0] elig;
        elig = f & (F_INV | F_DZE | F_OVF);
        if (u) elig |= f & (F_UNF | F_IOV);
        if (i) elig |= f & F_INE;
        if (s) elig &= ~m;
        return (elig == 0) ? 7'h00 : {elig, s};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; raw_flags = '0; q_underflow = 0;
        q_inexact = 0; q_swc = 0; dst_reg = '0; inst_pc = '0; dis_mask = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // issue one instruction; outputs are sampled at the following negedge
    task automatic issue(input logic [5:0] f, input logic u, input logic i, input logic s,
                         input logic [5:0] m, input logic [4:0] d, input logic [63:0] pc);
        raw_flags = f; q_underflow = u; q_inexact = i; q_swc = s;
        dis_mask = m; dst_reg = d; inst_pc = pc; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_trap(input string req, input logic [5:0] f, input logic u,
                               input logic i, input logic s, input logic [5:0] m,
                               input logic [4:0] d, input logic [63:0] pc);
        logic [6:0] es;
        es = exp_sum(f, u, i, s, m);
        issue(f, u, i, s, m, d, pc);
        check(req, "trap_valid", 64'(trap_valid), 64'(es != 0));
        if (es != 0) begin
            check(req, "trap_sum", 64'(trap_sum), 64'(es));
            check("R8", "trap_regmask", trap_regmask, 64'(1) << (d + 32));
            check("R9", "trap_pc", trap_pc, pc + 64'd4);
        end
        @(negedge clk);
        check("R10", "pulse ends", 64'(trap_valid), 64'd0);
    endtask

    task automatic t_reset();
        do_reset();
        check("R12", "sticky after reset", 64'(sticky), 64'd0);
        check("R12", "summary after reset", 64'(summary), 64'd0);
        check("R12", "trap_valid after reset", 64'(trap_valid), 64'd0);
        check("R11", "status_word after reset", status_word, 64'd0);
    endtask

    task automatic t_default_quals();
        do_reset();
        // R3 R4: unf, ine, iov ignored without qualifiers; R1: still sticky
        issue(F_UNF | F_INE | F_IOV, 0, 0, 0, '0, 5'd3, 64'h100);
        check("R10", "no trap default", 64'(trap_valid), 64'd0);
        check("R1", "sticky default", 64'(sticky), 64'(F_UNF | F_INE | F_IOV));
        check("R2", "summary set", 64'(summary), 64'd1);
    endtask

    task automatic t_always_eligible();
        do_reset();
        expect_trap("R5", F_INV, 0, 0, 0, '0, 5'd5, 64'h1000);
        expect_trap("R5", F_DZE | F_OVF, 0, 0, 0, '0, 5'd0, 64'h2000);
        check("R1", "sticky accum", 64'(sticky), 64'(F_INV | F_DZE | F_OVF));
    endtask

    task automatic t_qualified();
        do_reset();
        expect_trap("R4", F_UNF | F_IOV, 1, 0, 0, '0, 5'd7, 64'h3000);
        expect_trap("R3", F_INE, 0, 1, 0, '0, 5'd31, 64'hFFFF_FFFF_FFFF_FFFC);
        expect_trap("R7", F_UNF | F_INE | F_IOV | F_INV, 1, 1, 0, '0, 5'd12, 64'h40);
    endtask

    task automatic t_mask();
        do_reset();
        // R6 mask ignored without software completion
        expect_trap("R6", F_DZE, 0, 0, 0, 6'h3F, 5'd2, 64'h500);
        // R6 mask filters with software completion, R7 swc bit
        expect_trap("R6", F_DZE | F_OVF, 0, 0, 1, F_DZE, 5'd9, 64'h600);
        // R6 everything disabled: no trap, but R1 sticky still captures
        do_reset();
        issue(F_OVF, 0, 0, 1, 6'h3F, 5'd1, 64'h700);
        check("R6", "masked no trap", 64'(trap_valid), 64'd0);
        check("R1", "masked still sticky", 64'(sticky), 64'(F_OVF));
    endtask

    task automatic t_status_word();
        do_reset();
        issue(F_INV | F_IOV, 0, 0, 0, F_INE, 5'd0, 64'h0);
        check("R11", "status_word", status_word,
              (64'd1 << 63) | (64'd1 << 62) | (64'(F_INV | F_IOV) << 52));
        dis_mask = '0;
        #1;
        check("R11", "ine disable bit", 64'(status_word[62]), 64'd0);
        check("R2", "summary bit 63", 64'(status_word[63]), 64'd1);
    endtask

    initial begin
        t_reset();
        t_default_quals();
        t_always_eligible();
        t_qualified();
        t_mask();
        t_status_word();
        done = 1;
    end

    initial begin
        for (int n = 0; n < 20000 && !done; n++) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule